// File: doc/BRIEF.md
# Transceiver Control Register Bank with Set/Clear Aliases

This block is the register file on the transceiver side of a USB link. A link controller reaches it through a byte-wide port: an 8-bit address, 8-bit write data, a write strobe, a read strobe and an 8-bit registered read result. Six control registers can each be changed three ways: overwrite, bitwise OR, or bitwise clear. Each way has its own address, so firmware can change single bits without first reading the register.

Beside the control registers, the bank holds four read-only identification bytes, a live view of five transceiver status inputs and a view of the two line-state inputs. It also holds an event latch. The latch records rising or falling transitions of the status inputs, and each direction has its own per-bit enable register. Reading the latch returns it and empties it. Writing the transceiver reset bit in function control gives a one-cycle reset pulse and does not change the stored registers.

Top module: `xcvrCtlRegs`

## Requirements
- R1: While `rstN` is low, function control is 0x41 and every other writable register is 0x00. `regRdData` is 0x00 and `xcvrRst` is 0.
- R2: The control registers have these base addresses: function control 0x04, interface control 0x07, OTG control 0x0A, rising enable 0x0D, falling enable 0x10, scratch 0x16. A write to base+0 overwrites the register. A write to base+1 ORs the data into it. A write to base+2 clears the bits that are 1 in the data. The new value is visible from the clock edge that samples `regWrEn`. A read of any of the three addresses returns the current value.
- R3: Address 0x00 reads `VENDOR_ID[7:0]`, 0x01 reads `VENDOR_ID[15:8]`, 0x02 reads `PRODUCT_ID[7:0]` and 0x03 reads `PRODUCT_ID[15:8]`.
- R4: Bits 7 and 5 of function control always read 0. A write through 0x04 or 0x05 with data bit 5 set drives `xcvrRst` high for exactly the next cycle. A write through 0x06 never pulses `xcvrRst`.
- R5: Address 0x13 reads `{3'b000, statusIn}` as sampled at the read edge.
- R6: Latch bit i sets when `statusIn[i]` is 1 at a clock edge and was 0 at the previous edge, and rising-enable bit i is 1. It also sets when `statusIn[i]` goes from 1 to 0 and falling-enable bit i is 1. Once set, a bit holds until the latch is read.
- R7: A read of 0x14 returns the latch contents and clears the latch. An enabled transition detected at the same edge is not included in that read, and its bit remains set afterwards.
- R8: Address 0x15 reads `{6'b0, lineState}`.
- R9: Reads of 0x19 to 0xFF return 0x00. Writes to 0x19 to 0xFF, and to the read-only addresses 0x00 to 0x03 and 0x13 to 0x15, change no register and cause no pulse.
- R10: `regRdData` changes only at an edge where `regRdEn` is 1 and holds its value otherwise. If a read and a write fall in the same cycle, the read returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | 8 | Register address |
| regWrData | input | 8 | Write data |
| regWrEn | input | 1 | Write strobe |
| regRdEn | input | 1 | Read strobe |
| regRdData | output | 8 | Registered read result |
| statusIn | input | 5 | Status inputs: disconnect, VBUS valid, session valid, session end, ID grounded |
| lineState | input | 2 | Line-state inputs |
| funcCtrl | output | 8 | Function control register |
| ifaceCtrl | output | 8 | Interface control register |
| otgCtrl | output | 8 | OTG control register |
| xcvrRst | output | 1 | One-cycle transceiver reset pulse |

## Verification
The risky overlap is a latch read at the same edge where an enabled status transition is detected. A correct design returns the old contents and keeps the new bit. A faulty one either loses the event or reports it twice. The bench provokes this overlap on purpose: it toggles `statusIn` in the very cycle it reads 0x14, then reads again and expects only the new bit. A random phase then mixes reads, writes to every alias and status changes. A behavioural model checks that phase on every clock. The second overlap is a read and a write to the same register in one cycle, which must return the value from before the write.

// File: rtl/xcvrRegPkg.sv
package xcvrRegPkg;
  localparam int DATA_W    = 8;
  localparam int ADDR_W    = 8;
  localparam int NUM_CTL   = 6;
  localparam int NUM_STAT  = 5;
  localparam int NUM_LINE  = 2;
  localparam int NUM_ID    = 4;
  localparam int CTL_IDX_W = $clog2(NUM_CTL);
  localparam int ALIAS_N   = 3;

  localparam int FUNC_IDX  = 0;
  localparam int IFACE_IDX = 1;
  localparam int OTG_IDX   = 2;
  localparam int RISE_IDX  = 3;
  localparam int FALL_IDX  = 4;
  localparam int SCR_IDX   = 5;

  localparam logic [ADDR_W-1:0] ADDR_ID_LAST = 8'h03;
  localparam logic [ADDR_W-1:0] ADDR_STATUS  = 8'h13;
  localparam logic [ADDR_W-1:0] ADDR_LATCH   = 8'h14;
  localparam logic [ADDR_W-1:0] ADDR_DEBUG   = 8'h15;
  localparam logic [ADDR_W-1:0] ADDR_SCRATCH = 8'h16;
  localparam logic [ADDR_W-1:0] ADDR_CTL0    = 8'h04;

  localparam int FUNC_RST_BIT = 5;
  localparam logic [DATA_W-1:0] FUNC_KEEP_MASK = 8'h5F;
  localparam logic [DATA_W-1:0] FUNC_RESET_VAL = 8'h41;

  typedef enum logic [1:0] {OP_WRITE, OP_SET, OP_CLEAR, OP_NONE} ctlOpE;
  typedef enum logic [2:0] {RD_ZERO, RD_ID, RD_CTL, RD_STATUS, RD_LATCH, RD_DEBUG} rdKindE;

  typedef struct packed {
    logic [NUM_CTL-1:0]   ctlHit;
    ctlOpE                op;
    logic                 rdStb;
    rdKindE               rdKind;
    logic [CTL_IDX_W-1:0] rdCtlIdx;
    logic [1:0]           idSel;
    logic                 latchClr;
  } strobeT;

  function automatic logic [ADDR_W-1:0] ctlBase(int idx);
    return (idx == SCR_IDX) ? ADDR_SCRATCH : ADDR_W'(int'(ADDR_CTL0) + ALIAS_N * idx);
  endfunction

  function automatic logic [DATA_W-1:0] ctlKeepMask(int idx);
    return (idx == FUNC_IDX) ? FUNC_KEEP_MASK : {DATA_W{1'b1}};
  endfunction

  function automatic logic [DATA_W-1:0] ctlResetVal(int idx);
    return (idx == FUNC_IDX) ? FUNC_RESET_VAL : '0;
  endfunction
endpackage

// File: rtl/xcvrRegDecode.sv
module xcvrRegDecode
  import xcvrRegPkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              rdEn,
  output strobeT            stb
);
  logic [NUM_CTL-1:0] inWin;
  logic [1:0]         winOff [NUM_CTL];

  for (genvar g = 0; g < NUM_CTL; g++) begin : gWin
    logic [ADDR_W-1:0] rel;
    assign rel       = addr - ctlBase(g);
    assign inWin[g]  = rel < ADDR_W'(ALIAS_N);
    assign winOff[g] = rel[1:0];
  end

  always_comb begin
    stb          = '0;
    stb.op       = OP_NONE;
    stb.rdKind   = RD_ZERO;
    stb.rdStb    = rdEn;
    stb.idSel    = addr[1:0];
    stb.latchClr = rdEn && (addr == ADDR_LATCH);
    if (addr <= ADDR_ID_LAST)     stb.rdKind = RD_ID;
    else if (addr == ADDR_STATUS) stb.rdKind = RD_STATUS;
    else if (addr == ADDR_LATCH)  stb.rdKind = RD_LATCH;
    else if (addr == ADDR_DEBUG)  stb.rdKind = RD_DEBUG;
    for (int i = 0; i < NUM_CTL; i++) begin
      if (inWin[i]) begin
        stb.rdKind    = RD_CTL;
        stb.rdCtlIdx  = CTL_IDX_W'(i);
        stb.op        = ctlOpE'(winOff[i]);
        stb.ctlHit[i] = wrEn;
      end
    end
  end
endmodule

// File: rtl/xcvrRegData.sv
module xcvrRegData
  import xcvrRegPkg::*;
#(
  parameter logic [15:0] VENDOR_ID  = 16'hA5C3,
  parameter logic [15:0] PRODUCT_ID = 16'h0142
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobeT              stb,
  input  logic [DATA_W-1:0]   wrData,
  input  logic [NUM_STAT-1:0] statusIn,
  input  logic [NUM_LINE-1:0] lineState,
  output logic [DATA_W-1:0]   rdData,
  output logic [DATA_W-1:0]   funcCtrl,
  output logic [DATA_W-1:0]   ifaceCtrl,
  output logic [DATA_W-1:0]   otgCtrl,
  output logic                xcvrRst
);
  logic [DATA_W-1:0] ctlQ [NUM_CTL];
  logic [DATA_W-1:0] idByte [NUM_ID];
  logic [DATA_W-1:0] statWide, statPrev, edgeHit, latchQ, rdNext;

  assign idByte[0] = VENDOR_ID[7:0];
  assign idByte[1] = VENDOR_ID[15:8];
  assign idByte[2] = PRODUCT_ID[7:0];
  assign idByte[3] = PRODUCT_ID[15:8];

  // One storage slice per control register; the op comes from the decoder.
  for (genvar g = 0; g < NUM_CTL; g++) begin : gCtl
    logic [DATA_W-1:0] nxt;
    always_comb begin
      nxt = ctlQ[g];
      if (stb.ctlHit[g]) begin
        case (stb.op)
          OP_WRITE: nxt = wrData;
          OP_SET:   nxt = ctlQ[g] | wrData;
          OP_CLEAR: nxt = ctlQ[g] & ~wrData;
          default:  nxt = ctlQ[g];
        endcase
      end
    end
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) ctlQ[g] <= ctlResetVal(g);
      else       ctlQ[g] <= nxt & ctlKeepMask(g);
    end
  end

  // The reset bit is never stored; it only produces a pulse.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) xcvrRst <= 1'b0;
    else       xcvrRst <= stb.ctlHit[FUNC_IDX] && (stb.op != OP_CLEAR) && wrData[FUNC_RST_BIT];
  end

  assign statWide = DATA_W'(statusIn);
  assign edgeHit  = (statWide & ~statPrev & ctlQ[RISE_IDX]) |
                    (~statWide & statPrev & ctlQ[FALL_IDX]);

  // A clearing read keeps the edge found in the same cycle.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statPrev <= '0;
      latchQ   <= '0;
    end else begin
      statPrev <= statWide;
      latchQ   <= stb.latchClr ? edgeHit : (latchQ | edgeHit);
    end
  end

  always_comb begin
    case (stb.rdKind)
      RD_ID:     rdNext = idByte[stb.idSel];
      RD_CTL:    rdNext = ctlQ[stb.rdCtlIdx];
      RD_STATUS: rdNext = statWide;
      RD_LATCH:  rdNext = latchQ;
      RD_DEBUG:  rdNext = DATA_W'(lineState);
      default:   rdNext = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          rdData <= '0;
    else if (stb.rdStb) rdData <= rdNext;
  end

  assign funcCtrl  = ctlQ[FUNC_IDX];
  assign ifaceCtrl = ctlQ[IFACE_IDX];
  assign otgCtrl   = ctlQ[OTG_IDX];
endmodule

// File: rtl/xcvrCtlRegs.sv
module xcvrCtlRegs
  import xcvrRegPkg::*;
#(
  parameter logic [15:0] VENDOR_ID  = 16'hA5C3,
  parameter logic [15:0] PRODUCT_ID = 16'h0142
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] regAddr,
  input  logic [7:0] regWrData,
  input  logic       regWrEn,
  input  logic       regRdEn,
  output logic [7:0] regRdData,
  input  logic [4:0] statusIn,
  input  logic [1:0] lineState,
  output logic [7:0] funcCtrl,
  output logic [7:0] ifaceCtrl,
  output logic [7:0] otgCtrl,
  output logic       xcvrRst
);
  strobeT stb;

  xcvrRegDecode uDec (
    .addr (regAddr),
    .wrEn (regWrEn),
    .rdEn (regRdEn),
    .stb  (stb)
  );

  xcvrRegData #(.VENDOR_ID(VENDOR_ID), .PRODUCT_ID(PRODUCT_ID)) uData (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .wrData    (regWrData),
    .statusIn  (statusIn),
    .lineState (lineState),
    .rdData    (regRdData),
    .funcCtrl  (funcCtrl),
    .ifaceCtrl (ifaceCtrl),
    .otgCtrl   (otgCtrl),
    .xcvrRst   (xcvrRst)
  );
endmodule

// File: rtl/xcvrCtlRegsChk.sv
module xcvrCtlRegsChk (
  input logic       clk,
  input logic       rstN,
  input logic [7:0] regAddr,
  input logic [7:0] regWrData,
  input logic       regWrEn,
  input logic       regRdEn,
  input logic [7:0] regRdData,
  input logic [4:0] statusIn,
  input logic [1:0] lineState,
  input logic [7:0] funcCtrl,
  input logic [7:0] ifaceCtrl,
  input logic [7:0] otgCtrl,
  input logic       xcvrRst
);
  logic ctlWin;
  assign ctlWin = (regAddr >= 8'h04 && regAddr <= 8'h12) ||
                  (regAddr >= 8'h16 && regAddr <= 8'h18);

  a_r4_pulse_single: assert property (@(posedge clk) disable iff (!rstN)
    xcvrRst |=> !xcvrRst);

  a_r4_pulse_on_write: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && (regAddr == 8'h04 || regAddr == 8'h05) && regWrData[5]) |=> xcvrRst);

  a_r4_clear_no_pulse: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == 8'h06) |=> !xcvrRst);

  a_r2_set_alias: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == 8'h08) |=> ifaceCtrl == ($past(ifaceCtrl) | $past(regWrData)));

  a_r2_clear_alias: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == 8'h0C) |=> otgCtrl == ($past(otgCtrl) & ~$past(regWrData)));

  a_r9_ignored_write: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && !ctlWin) |=> ($stable(funcCtrl) && $stable(ifaceCtrl) && $stable(otgCtrl) && !xcvrRst));

  a_r5_status_read: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn && regAddr == 8'h13) |=> regRdData == {3'b000, $past(statusIn)});

  a_r8_debug_read: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn && regAddr == 8'h15) |=> regRdData == {6'b0, $past(lineState)});

  a_r10_hold: assert property (@(posedge clk) disable iff (!rstN)
    !regRdEn |=> $stable(regRdData));
endmodule

bind xcvrCtlRegs xcvrCtlRegsChk uChk (
  .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrData(regWrData),
  .regWrEn(regWrEn), .regRdEn(regRdEn), .regRdData(regRdData),
  .statusIn(statusIn), .lineState(lineState), .funcCtrl(funcCtrl),
  .ifaceCtrl(ifaceCtrl), .otgCtrl(otgCtrl), .xcvrRst(xcvrRst)
);

// File: tb/xcvrCtlRegs_test.sv
module xcvrCtlRegs_test;
  localparam logic [15:0] VID = 16'hA5C3;
  localparam logic [15:0] PID = 16'h0142;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rstN = 1'b0;
  logic [7:0] regAddr = '0, regWrData = '0;
  logic       regWrEn = 1'b0, regRdEn = 1'b0;
  logic [7:0] regRdData, funcCtrl, ifaceCtrl, otgCtrl;
  logic [4:0] statusIn = '0;
  logic [1:0] lineState = '0;
  logic       xcvrRst;

  xcvrCtlRegs #(.VENDOR_ID(VID), .PRODUCT_ID(PID)) uut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrData(regWrData),
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regRdData(regRdData),
    .statusIn(statusIn), .lineState(lineState), .funcCtrl(funcCtrl),
    .ifaceCtrl(ifaceCtrl), .otgCtrl(otgCtrl), .xcvrRst(xcvrRst)
  );

  int total = 0;
  int bad = 0;
  bit done = 0;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [7:0] mCtl [6];
  logic [4:0] mPrev, mLatch, mEd;
  logic [7:0] mRd, mVal;
  logic       mRst;
  string      mRdTag;
  int         mOff;

  function automatic int baseOf(int i);
    return (i == 5) ? 22 : 4 + 3 * i;
  endfunction

  function automatic logic [7:0] refRead(logic [7:0] a);
    logic [7:0] v = 8'h00;
    if (a == 8'h00) v = VID[7:0];
    else if (a == 8'h01) v = VID[15:8];
    else if (a == 8'h02) v = PID[7:0];
    else if (a == 8'h03) v = PID[15:8];
    else if (a == 8'h13) v = {3'b0, statusIn};
    else if (a == 8'h14) v = {3'b0, mLatch};
    else if (a == 8'h15) v = {6'b0, lineState};
    for (int i = 0; i < 6; i++)
      if (int'(a) >= baseOf(i) && int'(a) < baseOf(i) + 3) v = mCtl[i];
    return v;
  endfunction

  function automatic string refTag(logic [7:0] a);
    if (a <= 8'h03) return "R3";
    if (a == 8'h13) return "R5";
    if (a == 8'h14) return "R7";
    if (a == 8'h15) return "R8";
    if (a >= 8'h19) return "R9";
    return "R2";
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mCtl = '{8'h41, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
      mPrev = '0; mLatch = '0; mRd = '0; mRst = 1'b0; mRdTag = "R1";
    end else begin
      mEd = ((statusIn & ~mPrev) & mCtl[3][4:0]) | ((~statusIn & mPrev) & mCtl[4][4:0]);
      if (regRdEn) begin
        mRd = refRead(regAddr);
        mRdTag = refTag(regAddr);
      end else mRdTag = "R10";
      if (regRdEn && regAddr == 8'h14) mLatch = mEd;
      else mLatch = mLatch | mEd;
      mRst = 1'b0;
      if (regWrEn) begin
        for (int i = 0; i < 6; i++) begin
          mOff = int'(regAddr) - baseOf(i);
          if (mOff >= 0 && mOff < 3) begin
            case (mOff)
              0: mVal = regWrData;
              1: mVal = mCtl[i] | regWrData;
              default: mVal = mCtl[i] & ~regWrData;
            endcase
            if (i == 0) begin
              if (mOff != 2 && regWrData[5]) mRst = 1'b1;
              mVal = mVal & 8'h5F;
            end
            mCtl[i] = mVal;
          end
        end
      end
      mPrev = statusIn;
    end
  end

  always @(negedge clk) begin
    if (rstN && !done) begin
      check(mRdTag, regRdData, mRd);
      check("R2", funcCtrl, mCtl[0]);
      check("R2", ifaceCtrl, mCtl[1]);
      check("R2", otgCtrl, mCtl[2]);
      check("R4", xcvrRst, mRst);
    end
  end

  // ---------------- stimulus ----------------
  task automatic step(logic [7:0] a, logic [7:0] d, logic w, logic r);
    regAddr = a; regWrData = d; regWrEn = w; regRdEn = r;
    @(negedge clk);
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    step(a, d, 1'b1, 1'b0);
  endtask

  task automatic rdExp(logic [7:0] a, logic [7:0] exp, string tag);
    step(a, 8'h00, 1'b0, 1'b1);
    check(tag, regRdData, exp);
  endtask

  task automatic idle();
    step(8'h00, 8'h00, 1'b0, 1'b0);
  endtask

  task automatic finishRun();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    total++; bad++;
    $display("FAIL R10 watchdog expired act=hung exp=finished");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values
    check("R1", funcCtrl, 8'h41);
    check("R1", ifaceCtrl, 8'h00);
    check("R1", otgCtrl, 8'h00);
    check("R1", regRdData, 8'h00);
    check("R1", xcvrRst, 1'b0);
    rstN = 1'b1;
    idle();

    // R3: identification bytes
    rdExp(8'h00, VID[7:0], "R3");
    rdExp(8'h01, VID[15:8], "R3");
    rdExp(8'h02, PID[7:0], "R3");
    rdExp(8'h03, PID[15:8], "R3");

    // R2: write / set / clear aliases
    wr(8'h07, 8'hA5);
    rdExp(8'h07, 8'hA5, "R2");
    wr(8'h08, 8'h0A);
    rdExp(8'h09, 8'hAF, "R2");
    wr(8'h09, 8'h21);
    rdExp(8'h08, 8'h8E, "R2");
    wr(8'h16, 8'h3C);
    wr(8'h17, 8'hC0);
    wr(8'h18, 8'h0F);
    rdExp(8'h16, 8'hF0, "R2");

    // R4: reset pulse, bit never stored
    wr(8'h05, 8'h20);
    check("R4", xcvrRst, 1'b1);
    idle();
    check("R4", xcvrRst, 1'b0);
    rdExp(8'h04, 8'h41, "R4");
    wr(8'h04, 8'hFF);
    check("R4", funcCtrl, 8'h5F);
    check("R4", xcvrRst, 1'b1);
    wr(8'h06, 8'h20);
    check("R4", xcvrRst, 1'b0);

    // R9: ignored writes, reserved reads
    wr(8'h19, 8'hFF);
    wr(8'h13, 8'hFF);
    wr(8'h00, 8'h00);
    wr(8'hFF, 8'h00);
    wr(8'h15, 8'h00);
    check("R9", funcCtrl, 8'h5F);
    check("R9", ifaceCtrl, 8'h8E);
    check("R9", xcvrRst, 1'b0);
    rdExp(8'h19, 8'h00, "R9");
    rdExp(8'h2F, 8'h00, "R9");
    rdExp(8'hFF, 8'h00, "R9");

    // R6/R7: latch edges and clear on read
    wr(8'h0D, 8'h15);
    wr(8'h10, 8'h0A);
    statusIn = 5'h1F;
    idle();
    rdExp(8'h14, 8'h15, "R6");
    rdExp(8'h14, 8'h00, "R7");
    statusIn = 5'h00;
    idle();
    rdExp(8'h13, 8'h00, "R5");
    rdExp(8'h14, 8'h0A, "R6");
    // edge in the same cycle as the clearing read
    statusIn = 5'h01;
    rdExp(8'h14, 8'h00, "R7");
    rdExp(8'h14, 8'h01, "R7");
    statusIn = 5'h1B;
    rdExp(8'h13, 8'h1B, "R5");

    // R8: line state
    lineState = 2'b10;
    rdExp(8'h15, 8'h02, "R8");

    // R10: read and write in one cycle, then hold
    step(8'h0A, 8'h33, 1'b1, 1'b1);
    check("R10", regRdData, 8'h00);
    check("R10", otgCtrl, 8'h33);
    idle();
    check("R10", regRdData, 8'h00);

    // random mix, judged by the model
    for (int n = 0; n < 4000; n++) begin
      logic [7:0] a;
      a = ($urandom_range(0, 15) == 0) ? 8'($urandom_range(25, 255)) : 8'($urandom_range(0, 24));
      if ($urandom_range(0, 3) == 0) statusIn = 5'($urandom);
      if ($urandom_range(0, 7) == 0) lineState = 2'($urandom);
      step(a, 8'($urandom), 1'($urandom_range(0, 2) == 0), 1'($urandom_range(0, 1)));
    end
    idle();
    finishRun();
  end
endmodule